// File: doc/BRIEF.md
# ATA DMA Transfer Sequencer

This block steers one multi-chunk DMA command on an ATA/ATAPI device channel. A start command captures the command parameters, clears the byte index, loads the number of bytes still owed (sector count times 512 for a disk, the packet transfer size for an optical drive), raises the active flag and kicks the descriptor engine. The descriptor engine then offers chunks one at a time through a callback strobe carrying an error flag and a chunk length.

For every callback the sequencer picks exactly one outcome: report an error, stall until the channel is restarted, finish the whole command, end only the current chunk, copy packet data directly, flag an unsupported command, or issue a storage operation with a computed byte offset. Issuing moves the index forward and the remaining count down by the chunk length. Finishing raises the completion interrupt with the ready and seek-complete status for a disk, or a packet-OK pulse for an optical drive. The descriptor engine and the data movement sit outside and are reached through the request pulses at the ports.

Top module: `ata_dma_seq`

## Requirements
- R1: After reset `active_o` is 0, `status_o` is 0x00 and every pulse output (`kick_o`, `op_valid_o`, `copy_valid_o`, `chunk_end_o`, `stall_o`, `fatal_o`, `irq_o`, `pkt_ok_o`, `dma_err_o`, `pkt_err_o`) is 0.
- R2: A start pulse sets `active_o`, pulses `kick_o`, clears `status_o` to 0x00, clears the byte index and loads the remaining count with `sectors_i`×512 when `optical_i`=0 or `pkt_bytes_i` when `optical_i`=1; start wins over a callback in the same cycle.
- R3: Callback checks follow a fixed priority: error, then inactive, then remaining ≤ 0, then zero length; an error is reported even when the sequencer is not active.
- R4: A callback with `cb_err_i`=1 pulses `chunk_end_o` together with `dma_err_o` (disk) or `pkt_err_o` (optical) and leaves `active_o` unchanged.
- R5: A callback without error while inactive pulses `stall_o` only: no completion, no chunk end, no operation.
- R6: An active disk callback with remaining ≤ 0 pulses `irq_o` and `chunk_end_o`, sets `status_o` to 0x50 (ready 0x40 plus seek-complete 0x10) and clears `active_o`.
- R7: An active optical callback with remaining ≤ 0 pulses `pkt_ok_o` and `chunk_end_o`, clears `active_o` and leaves `status_o` unchanged.
- R8: An active callback with positive remaining and `cb_len_i`=0 pulses `chunk_end_o` only; `active_o` stays 1.
- R9: A disk operation carries `op_offset_o` = start sector×512 + index and `op_len_o` = `cb_len_i`; afterwards the index grows and the remaining count shrinks by `cb_len_i` (remaining may go negative).
- R10: An optical operation (LBA not all ones) carries `op_offset_o` = LBA×2048 + index and `op_kind_o` = 0 (read).
- R11: An optical command whose LBA is all ones pulses `copy_valid_o` with `copy_len_o` = min(remaining, `cb_len_i`), pulses `pkt_ok_o` and `chunk_end_o`, and clears `active_o`.
- R12: Disk command codes 0, 1, 2 issue read, write, trim with the same value on `op_kind_o`; code 3 pulses `fatal_o` only and changes no state.
- R13: Every output is registered: a result appears in the cycle after its start or callback and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command pulse |
| optical_i | input | 1 | 1 = optical (packet) device, 0 = disk |
| cmd_i | input | 2 | Disk command: 0 read, 1 write, 2 trim, 3 unsupported |
| sectors_i | input | SECT_W | Disk sector count |
| pkt_bytes_i | input | SIZE_W | Optical packet transfer size in bytes |
| start_sector_i | input | LBA_W | Disk start sector |
| lba_i | input | LBA_W | Optical block address, all ones = non-block data |
| cb_valid_i | input | 1 | Chunk callback strobe from the descriptor engine |
| cb_err_i | input | 1 | Callback reports an error |
| cb_len_i | input | SIZE_W | Chunk length in bytes |
| kick_o | output | 1 | Pulse: kick the descriptor engine |
| op_valid_o | output | 1 | Pulse: issue a storage operation |
| op_kind_o | output | 2 | Operation kind: 0 read, 1 write, 2 trim |
| op_offset_o | output | OFF_W | Storage byte offset of the operation |
| op_len_o | output | SIZE_W | Operation length in bytes |
| copy_valid_o | output | 1 | Pulse: copy device buffer straight to memory |
| copy_len_o | output | SIZE_W | Copy length in bytes |
| chunk_end_o | output | 1 | Pulse: current chunk is finished |
| stall_o | output | 1 | Pulse: processing dropped, wait for restart |
| fatal_o | output | 1 | Pulse: unsupported disk command |
| irq_o | output | 1 | Pulse: disk command completion interrupt |
| pkt_ok_o | output | 1 | Pulse: packet command completed |
| dma_err_o | output | 1 | Pulse: disk DMA error |
| pkt_err_o | output | 1 | Pulse: packet I/O error |
| active_o | output | 1 | Transfer active flag |
| status_o | output | 8 | Device status byte |

## Verification
A wrong remaining count shows one or more callbacks later as a completion that arrives too early or too late, or as a copy of the wrong length, while a wrong index shows on the very next operation as an offset off by the missing bytes. A corrupted active flag shows at the next callback as a stall where an operation was due, or the reverse. Wrong outcome priority shows in the cycle after a single callback, so the bench compares every output after every start and callback against a model built from the requirements, under long random mixes of errors, zero lengths, restarts and all command codes.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;

  typedef enum logic [2:0] {
    OC_ERROR,
    OC_STALL,
    OC_FINISH,
    OC_CHUNK_END,
    OC_COPY,
    OC_BADCMD,
    OC_ISSUE
  } outcome_e;

  localparam logic [1:0] KIND_READ  = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_TRIM  = 2'd2;
  localparam logic [1:0] KIND_BAD   = 2'd3;

  localparam logic [7:0] STAT_READY = 8'h40;
  localparam logic [7:0] STAT_SEEK  = 8'h10;

  localparam int DISK_SHIFT    = 9;
  localparam int OPTICAL_SHIFT = 11;

endpackage

// File: rtl/seq_decide.sv
module seq_decide
  import ata_seq_pkg::*;
#(
  parameter int REM_W = 27,
  parameter int LEN_W = 26
) (
  input  logic                    err,
  input  logic                    active,
  input  logic signed [REM_W-1:0] remaining,
  input  logic [LEN_W-1:0]        len,
  input  logic                    optical,
  input  logic                    raw_data,
  input  logic [1:0]              cmd,
  output outcome_e                outcome
);

  logic rem_spent;
  assign rem_spent = remaining[REM_W-1] || (remaining == '0);

  always_comb begin
    if (err)                            outcome = OC_ERROR;
    else if (!active)                   outcome = OC_STALL;
    else if (rem_spent)                 outcome = OC_FINISH;
    else if (len == '0)                 outcome = OC_CHUNK_END;
    else if (optical && raw_data)       outcome = OC_COPY;
    else if (!optical && cmd == KIND_BAD) outcome = OC_BADCMD;
    else                                outcome = OC_ISSUE;
  end

endmodule

// File: rtl/seq_offset.sv
module seq_offset
  import ata_seq_pkg::*;
#(
  parameter int LBA_W = 32,
  parameter int IDX_W = 27,
  parameter int OFF_W = 44
) (
  input  logic             optical,
  input  logic [LBA_W-1:0] sector,
  input  logic [LBA_W-1:0] lba,
  input  logic [IDX_W-1:0] index,
  output logic [OFF_W-1:0] offset
);

  logic [OFF_W-1:0] base;

  always_comb begin
    if (optical) base = OFF_W'(lba) << OPTICAL_SHIFT;
    else         base = OFF_W'(sector) << DISK_SHIFT;
    offset = base + OFF_W'(index);
  end

endmodule

// File: rtl/ata_dma_seq.sv
module ata_dma_seq
  import ata_seq_pkg::*;
#(
  parameter int SECT_W = 16,
  parameter int SIZE_W = 26,
  parameter int LBA_W  = 32,
  localparam int REM_W = SIZE_W + 1,
  localparam int OFF_W = LBA_W + OPTICAL_SHIFT + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              optical_i,
  input  logic [1:0]        cmd_i,
  input  logic [SECT_W-1:0] sectors_i,
  input  logic [SIZE_W-1:0] pkt_bytes_i,
  input  logic [LBA_W-1:0]  start_sector_i,
  input  logic [LBA_W-1:0]  lba_i,
  input  logic              cb_valid_i,
  input  logic              cb_err_i,
  input  logic [SIZE_W-1:0] cb_len_i,
  output logic              kick_o,
  output logic              op_valid_o,
  output logic [1:0]        op_kind_o,
  output logic [OFF_W-1:0]  op_offset_o,
  output logic [SIZE_W-1:0] op_len_o,
  output logic              copy_valid_o,
  output logic [SIZE_W-1:0] copy_len_o,
  output logic              chunk_end_o,
  output logic              stall_o,
  output logic              fatal_o,
  output logic              irq_o,
  output logic              pkt_ok_o,
  output logic              dma_err_o,
  output logic              pkt_err_o,
  output logic              active_o,
  output logic [7:0]        status_o
);

  localparam int IDX_W = REM_W;

  // latched command context
  logic                    opt_q;
  logic [1:0]              cmd_q;
  logic [LBA_W-1:0]        sector_q;
  logic [LBA_W-1:0]        lba_q;
  logic signed [REM_W-1:0] rem_q;
  logic [IDX_W-1:0]        idx_q;
  logic                    active_q;

  outcome_e                outcome;
  logic [OFF_W-1:0]        offset_w;
  logic signed [REM_W-1:0] len_s;
  logic [SIZE_W-1:0]       copy_len_w;
  logic [REM_W-1:0]        start_rem;

  assign len_s = $signed({1'b0, cb_len_i});

  // remaining is positive whenever a copy is chosen
  assign copy_len_w = (len_s < rem_q) ? cb_len_i : rem_q[SIZE_W-1:0];

  assign start_rem = optical_i ? REM_W'(pkt_bytes_i)
                               : (REM_W'(sectors_i) << DISK_SHIFT);

  seq_decide #(.REM_W(REM_W), .LEN_W(SIZE_W)) decide_i (
    .err       (cb_err_i),
    .active    (active_q),
    .remaining (rem_q),
    .len       (cb_len_i),
    .optical   (opt_q),
    .raw_data  (&lba_q),
    .cmd       (cmd_q),
    .outcome   (outcome)
  );

  seq_offset #(.LBA_W(LBA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) offset_i (
    .optical (opt_q),
    .sector  (sector_q),
    .lba     (lba_q),
    .index   (idx_q),
    .offset  (offset_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_q        <= 1'b0;
      cmd_q        <= KIND_READ;
      sector_q     <= '0;
      lba_q        <= '0;
      rem_q        <= '0;
      idx_q        <= '0;
      active_q     <= 1'b0;
      status_o     <= 8'h00;
      kick_o       <= 1'b0;
      op_valid_o   <= 1'b0;
      op_kind_o    <= KIND_READ;
      op_offset_o  <= '0;
      op_len_o     <= '0;
      copy_valid_o <= 1'b0;
      copy_len_o   <= '0;
      chunk_end_o  <= 1'b0;
      stall_o      <= 1'b0;
      fatal_o      <= 1'b0;
      irq_o        <= 1'b0;
      pkt_ok_o     <= 1'b0;
      dma_err_o    <= 1'b0;
      pkt_err_o    <= 1'b0;
    end else begin
      kick_o       <= 1'b0;
      op_valid_o   <= 1'b0;
      copy_valid_o <= 1'b0;
      chunk_end_o  <= 1'b0;
      stall_o      <= 1'b0;
      fatal_o      <= 1'b0;
      irq_o        <= 1'b0;
      pkt_ok_o     <= 1'b0;
      dma_err_o    <= 1'b0;
      pkt_err_o    <= 1'b0;
      if (start_i) begin
        opt_q    <= optical_i;
        cmd_q    <= cmd_i;
        sector_q <= start_sector_i;
        lba_q    <= lba_i;
        rem_q    <= $signed(start_rem);
        idx_q    <= '0;
        active_q <= 1'b1;
        status_o <= 8'h00;
        kick_o   <= 1'b1;
      end else if (cb_valid_i) begin
        unique case (outcome)
          OC_ERROR: begin
            chunk_end_o <= 1'b1;
            if (opt_q) pkt_err_o <= 1'b1;
            else       dma_err_o <= 1'b1;
          end
          OC_STALL: stall_o <= 1'b1;
          OC_FINISH: begin
            chunk_end_o <= 1'b1;
            active_q    <= 1'b0;
            if (opt_q) begin
              pkt_ok_o <= 1'b1;
            end else begin
              irq_o    <= 1'b1;
              status_o <= STAT_READY | STAT_SEEK;
            end
          end
          OC_CHUNK_END: chunk_end_o <= 1'b1;
          OC_COPY: begin
            copy_valid_o <= 1'b1;
            copy_len_o   <= copy_len_w;
            pkt_ok_o     <= 1'b1;
            chunk_end_o  <= 1'b1;
            active_q     <= 1'b0;
          end
          OC_BADCMD: fatal_o <= 1'b1;
          default: begin
            op_valid_o  <= 1'b1;
            op_kind_o   <= opt_q ? KIND_READ : cmd_q;
            op_offset_o <= offset_w;
            op_len_o    <= cb_len_i;
            rem_q       <= rem_q - len_s;
            idx_q       <= idx_q + IDX_W'(cb_len_i);
          end
        endcase
      end
    end
  end

  assign active_o = active_q;

endmodule

// File: rtl/ata_dma_seq_chk.sv
module ata_dma_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       cb_valid_i,
  input logic       cb_err_i,
  input logic       kick_o,
  input logic       op_valid_o,
  input logic       copy_valid_o,
  input logic       chunk_end_o,
  input logic       stall_o,
  input logic       fatal_o,
  input logic       irq_o,
  input logic       pkt_ok_o,
  input logic       dma_err_o,
  input logic       pkt_err_o,
  input logic       active_o,
  input logic [7:0] status_o
);

  // R2
  start_kick_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (active_o && kick_o && status_o == 8'h00));

  // R4
  err_report_chk: assert property (@(posedge clk) disable iff (rst)
    (cb_valid_i && cb_err_i && !start_i) |=>
      (chunk_end_o && (dma_err_o ^ pkt_err_o) && $stable(active_o)));

  // R5
  idle_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (cb_valid_i && !cb_err_i && !start_i && !active_o) |=>
      (stall_o && !chunk_end_o && !irq_o && !pkt_ok_o && !op_valid_o));

  // R6
  disk_done_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (status_o == 8'h50 && !active_o && chunk_end_o));

  // R12
  outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({op_valid_o, chunk_end_o, stall_o, fatal_o, kick_o}));

  // R13
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cb_valid_i && !start_i) |=>
      !(kick_o || op_valid_o || copy_valid_o || chunk_end_o || stall_o ||
        fatal_o || irq_o || pkt_ok_o || dma_err_o || pkt_err_o));

  // R11
  copy_done_chk: assert property (@(posedge clk) disable iff (rst)
    copy_valid_o |-> (pkt_ok_o && chunk_end_o && !active_o));

endmodule

bind ata_dma_seq ata_dma_seq_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .cb_valid_i   (cb_valid_i),
  .cb_err_i     (cb_err_i),
  .kick_o       (kick_o),
  .op_valid_o   (op_valid_o),
  .copy_valid_o (copy_valid_o),
  .chunk_end_o  (chunk_end_o),
  .stall_o      (stall_o),
  .fatal_o      (fatal_o),
  .irq_o        (irq_o),
  .pkt_ok_o     (pkt_ok_o),
  .dma_err_o    (dma_err_o),
  .pkt_err_o    (pkt_err_o),
  .active_o     (active_o),
  .status_o     (status_o)
);

// File: tb/ata_dma_seq_tb_top.sv
`timescale 1ns/1ps
module ata_dma_seq_tb_top;

  localparam int SECT_W = 16;
  localparam int SIZE_W = 26;
  localparam int LBA_W  = 32;
  localparam int OFF_W  = LBA_W + 12;
  localparam longint ALL_ONES = 64'hFFFF_FFFF;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic              optical_i = 1'b0;
  logic [1:0]        cmd_i = '0;
  logic [SECT_W-1:0] sectors_i = '0;
  logic [SIZE_W-1:0] pkt_bytes_i = '0;
  logic [LBA_W-1:0]  start_sector_i = '0;
  logic [LBA_W-1:0]  lba_i = '0;
  logic              cb_valid_i = 1'b0;
  logic              cb_err_i = 1'b0;
  logic [SIZE_W-1:0] cb_len_i = '0;
  logic              kick_o, op_valid_o, copy_valid_o, chunk_end_o, stall_o;
  logic              fatal_o, irq_o, pkt_ok_o, dma_err_o, pkt_err_o, active_o;
  logic [1:0]        op_kind_o;
  logic [OFF_W-1:0]  op_offset_o;
  logic [SIZE_W-1:0] op_len_o, copy_len_o;
  logic [7:0]        status_o;

  always #2 clk = ~clk;

  ata_dma_seq #(.SECT_W(SECT_W), .SIZE_W(SIZE_W), .LBA_W(LBA_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .optical_i(optical_i),
    .cmd_i(cmd_i), .sectors_i(sectors_i), .pkt_bytes_i(pkt_bytes_i),
    .start_sector_i(start_sector_i), .lba_i(lba_i), .cb_valid_i(cb_valid_i),
    .cb_err_i(cb_err_i), .cb_len_i(cb_len_i), .kick_o(kick_o),
    .op_valid_o(op_valid_o), .op_kind_o(op_kind_o), .op_offset_o(op_offset_o),
    .op_len_o(op_len_o), .copy_valid_o(copy_valid_o), .copy_len_o(copy_len_o),
    .chunk_end_o(chunk_end_o), .stall_o(stall_o), .fatal_o(fatal_o),
    .irq_o(irq_o), .pkt_ok_o(pkt_ok_o), .dma_err_o(dma_err_o),
    .pkt_err_o(pkt_err_o), .active_o(active_o), .status_o(status_o)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // model state, built from the requirements
  bit     m_active = 0;
  bit     m_opt = 0;
  int     m_cmd = 0;
  longint m_sector = 0, m_lba = 0, m_rem = 0, m_idx = 0;
  int     m_status = 0;

  // expected pulses and data
  bit     e_kick, e_op, e_copy, e_chunk, e_stall, e_fatal, e_irq, e_pok, e_derr, e_perr;
  longint e_kind, e_off, e_len, e_clen;

  task automatic cmp(input string tag, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_exp();
    {e_kick, e_op, e_copy, e_chunk, e_stall, e_fatal, e_irq, e_pok, e_derr, e_perr} = '0;
  endtask

  task automatic compare_all(input string tag);
    cmp(tag, "kick", kick_o, e_kick);
    cmp(tag, "op_valid", op_valid_o, e_op);
    cmp(tag, "copy_valid", copy_valid_o, e_copy);
    cmp(tag, "chunk_end", chunk_end_o, e_chunk);
    cmp(tag, "stall", stall_o, e_stall);
    cmp(tag, "fatal", fatal_o, e_fatal);
    cmp(tag, "irq", irq_o, e_irq);
    cmp(tag, "pkt_ok", pkt_ok_o, e_pok);
    cmp(tag, "dma_err", dma_err_o, e_derr);
    cmp(tag, "pkt_err", pkt_err_o, e_perr);
    cmp(tag, "active", active_o, m_active);
    cmp(tag, "status", status_o, m_status);
    if (e_op) begin
      cmp(tag, "op_kind", op_kind_o, e_kind);
      cmp(tag, "op_offset", op_offset_o, e_off);
      cmp(tag, "op_len", op_len_o, e_len);
    end
    if (e_copy) cmp(tag, "copy_len", copy_len_o, e_clen);
  endtask

  // inputs change on a falling edge, results are read one falling edge later
  task automatic do_start(input bit opt, input int cmd, input longint secs,
                          input longint pkt, input longint sect, input longint lba);
    optical_i = opt; cmd_i = 2'(cmd); sectors_i = SECT_W'(secs);
    pkt_bytes_i = SIZE_W'(pkt); start_sector_i = LBA_W'(sect); lba_i = LBA_W'(lba);
    start_i = 1'b1;
    clear_exp();
    e_kick = 1;
    m_active = 1; m_opt = opt; m_cmd = cmd; m_sector = sect; m_lba = lba;
    m_rem = opt ? pkt : secs * 512; m_idx = 0; m_status = 0;
    @(negedge clk);
    start_i = 1'b0;
    compare_all("R2");
  endtask

  task automatic do_cb(input bit err, input longint len);
    string tag;
    clear_exp();
    if (err) begin
      tag = m_active ? "R4" : "R3";
      e_chunk = 1;
      if (m_opt) e_perr = 1; else e_derr = 1;
    end else if (!m_active) begin
      tag = "R5"; e_stall = 1;
    end else if (m_rem <= 0) begin
      e_chunk = 1; m_active = 0;
      if (m_opt) begin tag = "R7"; e_pok = 1; end
      else begin tag = "R6"; e_irq = 1; m_status = 8'h50; end
    end else if (len == 0) begin
      tag = "R8"; e_chunk = 1;
    end else if (m_opt && m_lba == ALL_ONES) begin
      tag = "R11"; e_copy = 1; e_pok = 1; e_chunk = 1; m_active = 0;
      e_clen = (len < m_rem) ? len : m_rem;
    end else if (!m_opt && m_cmd == 3) begin
      tag = "R12"; e_fatal = 1;
    end else begin
      tag = m_opt ? "R10" : "R9";
      e_op = 1; e_len = len;
      e_kind = m_opt ? 0 : m_cmd;
      e_off = m_opt ? (m_lba * 2048 + m_idx) : (m_sector * 512 + m_idx);
      m_rem = m_rem - len; m_idx = m_idx + len;
    end
    cb_valid_i = 1'b1; cb_err_i = err; cb_len_i = SIZE_W'(len);
    @(negedge clk);
    cb_valid_i = 1'b0; cb_err_i = 1'b0;
    compare_all(tag);
  endtask

  task automatic idle_check();
    clear_exp();
    @(negedge clk);
    compare_all("R13");
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_2024;
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    clear_exp();
    compare_all("R1");

    // directed corners
    do_cb(0, 512);               // R5 inactive stall
    do_cb(1, 512);               // R3 error wins over inactive
    do_start(0, 0, 2, 0, 100, 0);
    do_cb(0, 512);               // R9 offset 51200
    do_cb(0, 0);                 // R8
    do_cb(0, 512);               // R9 offset 51712
    do_cb(0, 0);                 // R6 rem 0 beats zero length
    idle_check();
    do_start(0, 3, 1, 0, 5, 0);
    do_cb(0, 512);               // R12 fatal
    do_cb(1, 100);               // R4 error keeps active
    do_start(0, 1, 1, 0, 9, 0);
    do_cb(0, 700);               // R12 write, rem negative
    do_cb(0, 0);                 // R6
    do_start(0, 2, 3, 0, 1, 0);
    do_cb(0, 1536);              // R12 trim
    do_cb(0, 4);                 // R6
    do_start(1, 0, 0, 3000, 0, 7);
    do_cb(0, 2048);              // R10
    do_cb(0, 2048);              // R10
    do_cb(0, 16);                // R7
    do_start(1, 0, 0, 100, 0, ALL_ONES);
    do_cb(0, 512);               // R11 copy 100
    do_cb(0, 512);               // R5 after copy
    do_start(1, 0, 0, 4000, 0, ALL_ONES);
    do_cb(0, 300);               // R11 copy 300
    do_start(1, 0, 0, 64, 0, 3);
    do_cb(1, 8);                 // R4 packet error

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(99);
      if (r < 8) begin
        bit opt;
        opt = $urandom_range(1);
        do_start(opt, $urandom_range(3), $urandom_range(1, 16),
                 $urandom_range(1, 9000), $urandom_range(0, 2000000),
                 ($urandom_range(3) == 0) ? ALL_ONES : longint'($urandom_range(0, 500000)));
      end else begin
        bit err;
        longint len;
        err = ($urandom_range(19) == 0);
        len = ($urandom_range(4) == 0) ? 0 : longint'($urandom_range(1, 4096));
        do_cb(err, len);
      end
      if ($urandom_range(3) == 0) idle_check();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule